// File: doc/BRIEF.md
# Register-Window Watchdog Timer

This block is a countdown watchdog that software controls through a 32-byte register window of 16-bit registers. A free-running prescaler divides the clock into coarse ticks, nominally 0.6 s each. `TICK_CYCLES` sets the tick length so that a fast configuration can be built for simulation. Software stores a start value and a halt bit, and it restarts the countdown by writing to the count register. At any time it can read the live count and clear the expiry flags.

When the count runs out, the block sets a timeout flag, reloads itself from the start value and keeps counting. If a second run-out follows with no restart written in between, the block sets a second-timeout flag and raises a one-cycle reset request to the system. The `reboot_block` input suppresses that request but leaves the flags intact. The register port has no back-pressure. A write takes effect on the clock edge where `wr_en` is high. `rdata` is a combinational decode of `addr` and has no side effects.

Top module: `wdog_regwin`

## Requirements
- R1: After reset the control register reads 0x0800 (halted), the start-value register reads 0x0004, the count reads 4, both status registers read 0 and `wdt_rst_req` is low.
- R2: A read of offset 0x00 returns the live count in bits 9:0, with bits 15:10 zero. Any write to 0x00 loads the count from the start value and restarts the tick phase. Writes to other registers leave the count unchanged.
- R3: Offset 0x12 is a 16-bit read/write register whose bits 9:0 hold the start value. A write whose bits 9:0 are below 4 is dropped entirely, and the register keeps its previous contents.
- R4: Offset 0x08 is 16 bits of read/write storage. While bit 11 is 1 the count and tick phase are frozen. Clearing it resumes counting with a fresh tick phase.
- R5: While running, the count drops by one every `TICK_CYCLES` clocks. A tick that finds the count at 1 is an expiry and reloads the start value. An expiry therefore falls exactly N·TICK_CYCLES clocks after a restart with start value N.
- R6: Every expiry sets bit 0 of offset 0x04.
- R7: An expiry that follows an earlier expiry, with no restart written in between, sets bit 0 of offset 0x06 and pulses `wdt_rst_req` high for exactly one cycle in the same cycle. The pending state then clears, so the next pulse needs two more expiries.
- R8: While `reboot_block` is high, a second expiry does not pulse `wdt_rst_req`, but both status bits are still set.
- R9: A restart written between two expiries cancels the pending first expiry.
- R10: A restart written in the very cycle of an expiring tick wins. No status bit is set, and the count loads the start value.
- R11: In each status register, writing 1 to bit 0 clears it and writing 0 leaves it. All other status bits read 0. A set and a clear in the same cycle leave the bit set.
- R12: Offsets other than 0x00, 0x04, 0x06, 0x08 and 0x12 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 5 | Byte offset inside the register window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| reboot_block | input | 1 | When high, suppresses the reset request |
| wdt_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with `TICK_CYCLES` = 3. That brings every expiry within a few dozen clocks, so the bench can sweep every start value from 4 to 16 and time the first expiry, the second expiry and the reset pulse to the exact cycle against N·3 and 2·N·3. The short tick also lets it sample the live count on every clock of a full period and align a restart write precisely with an expiring tick. The illegal start values 0 to 3 are swept exhaustively.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CNT_W  = 10;

  localparam logic [ADDR_W-1:0] OFF_COUNT  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT_A = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT_B = 5'h06;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_INIT   = 5'h12;

  localparam int unsigned       HALT_POS   = 11;
  localparam logic [CNT_W-1:0]  INIT_FLOOR = 10'd4;
  localparam logic [DATA_W-1:0] CTRL_RST   = 16'h0800;
  localparam logic [DATA_W-1:0] INIT_RST   = 16'h0004;

  typedef struct packed {
    logic expire;
    logic second;
  } expiry_t;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int unsigned TICK_CYCLES = 60_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  generate
    if (TICK_CYCLES < 2) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(TICK_CYCLES);
      localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk) begin
        if (!rst_n)                                  phase_q <= '0;
        else if (!run_i || restart_i || phase_q == LAST) phase_q <= '0;
        else                                          phase_q <= phase_q + 1'b1;
      end

      assign tick_o = run_i && (phase_q == LAST);

      // R5
      phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);
    end
  endgenerate
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic             inhibit_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] count_o,
  output expiry_t          evt_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pending_q;
  logic             expire, second;

  assign expire  = tick_i && !reload_i && (cnt_q <= CNT_W'(1));
  assign second  = expire && pending_q;
  assign evt_o   = '{expire: expire, second: second};
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= INIT_RST[CNT_W-1:0];
      pending_q <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= second && !inhibit_i;
      if (reload_i) begin
        cnt_q     <= init_i;
        pending_q <= 1'b0;
      end else if (expire) begin
        cnt_q     <= init_i;
        pending_q <= !pending_q;
      end else if (tick_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R10
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == $past(init_i)));
  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  // R8
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !$past(inhibit_i));
  // R5
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  expiry_t           evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              halt_o,
  output logic [CNT_W-1:0]  init_o,
  output logic              reload_o
);
  logic [DATA_W-1:0] ctrl_q, init_q;
  logic              stat_a_q, stat_b_q;
  logic              hit_cnt, hit_a, hit_b, hit_ctrl, hit_init, init_ok;

  assign hit_cnt  = wr_en_i && (addr_i == OFF_COUNT);
  assign hit_a    = wr_en_i && (addr_i == OFF_STAT_A);
  assign hit_b    = wr_en_i && (addr_i == OFF_STAT_B);
  assign hit_ctrl = wr_en_i && (addr_i == OFF_CTRL);
  assign hit_init = wr_en_i && (addr_i == OFF_INIT);
  assign init_ok  = wdata_i[CNT_W-1:0] >= INIT_FLOOR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      init_q   <= INIT_RST;
      stat_a_q <= 1'b0;
      stat_b_q <= 1'b0;
    end else begin
      if (hit_ctrl)            ctrl_q <= wdata_i;
      if (hit_init && init_ok) init_q <= wdata_i;
      stat_a_q <= evt_i.expire | (stat_a_q & ~(hit_a & wdata_i[0]));
      stat_b_q <= evt_i.second | (stat_b_q & ~(hit_b & wdata_i[0]));
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_COUNT:  rdata_o = {{(DATA_W-CNT_W){1'b0}}, count_i};
      OFF_STAT_A: rdata_o = {{(DATA_W-1){1'b0}}, stat_a_q};
      OFF_STAT_B: rdata_o = {{(DATA_W-1){1'b0}}, stat_b_q};
      OFF_CTRL:   rdata_o = ctrl_q;
      OFF_INIT:   rdata_o = init_q;
      default:    rdata_o = '0;
    endcase
  end

  assign halt_o   = ctrl_q[HALT_POS];
  assign init_o   = init_q[CNT_W-1:0];
  assign reload_o = hit_cnt;

  // R3
  init_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_q[CNT_W-1:0] >= INIT_FLOOR);
  // R6
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.expire |=> stat_a_q);
  // R11
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && wdata_i[0] && !evt_i.expire) |=> !stat_a_q);
endmodule

// File: rtl/wdog_regwin.sv
module wdog_regwin
  import wdog_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 60_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              reboot_block,
  output logic              wdt_rst_req
);
  logic             halt, reload, tick;
  logic [CNT_W-1:0] init_val, count;
  expiry_t          evt;

  wdog_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .count_i(count), .evt_i(evt), .rdata_o(rdata), .halt_o(halt),
    .init_o(init_val), .reload_o(reload)
  );

  wdog_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(!halt), .restart_i(reload), .tick_o(tick)
  );

  wdog_countdown u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .reload_i(reload),
    .inhibit_i(reboot_block), .init_i(init_val), .count_o(count),
    .evt_o(evt), .rst_req_o(wdt_rst_req)
  );

  // R4
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload) |=> $stable(count));
endmodule

// File: tb/test_wdog_regwin.sv
module test_wdog_regwin;
  import wdog_pkg::*;
  localparam int CLK_P = 10;
  localparam int T = 3;

  logic clk = 0, rst_n = 0, wr_en = 0, reboot_block = 0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic wdt_rst_req;
  int checks = 0, errors = 0;

  wdog_regwin #(.TICK_CYCLES(T)) i_wdog_regwin (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .reboot_block(reboot_block), .wdt_rst_req(wdt_rst_req));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output int d);
    addr = a; #1; d = int'(rdata);
  endtask

  task automatic start_run(int n);
    wr(OFF_CTRL, 16'h0800); wr(OFF_INIT, 16'(n));
    wr(OFF_STAT_A, 16'h1); wr(OFF_STAT_B, 16'h1);
    wr(OFF_COUNT, 16'h0); wr(OFF_CTRL, 16'h0000);
  endtask

  task automatic watch(int ncyc, output int ka, output int kb, output int np, output int kp);
    ka = -1; kb = -1; np = 0; kp = -1; addr = OFF_STAT_A;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk); #1;
      if (wdt_rst_req) begin np++; kp = k; end
      if (addr == OFF_STAT_B) begin
        if (kb < 0 && rdata[0]) kb = k;
      end else if (ka < 0 && rdata[0]) begin
        ka = k; addr = OFF_STAT_B;
      end
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int v, ka, kb, np, kp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(OFF_CTRL, v);   chk("R1 ctrl", v, 16'h0800);
    rd(OFF_INIT, v);   chk("R1 init", v, 4);
    rd(OFF_COUNT, v);  chk("R1 count", v, 4);
    rd(OFF_STAT_A, v); chk("R1 stat_a", v, 0);
    rd(OFF_STAT_B, v); chk("R1 stat_b", v, 0);
    chk("R1 rst_req", int'(wdt_rst_req), 0);
    // R4 halted after reset: count frozen
    repeat (40) @(negedge clk);
    rd(OFF_COUNT, v); chk("R4 frozen at reset", v, 4);

    // R3 start-value legality sweep
    wr(OFF_INIT, 16'hFC05); rd(OFF_INIT, v); chk("R3 legal write", v, 16'hFC05);
    for (int i = 0; i < 4; i++) begin
      wr(OFF_INIT, 16'hA800 | 16'(i)); rd(OFF_INIT, v);
      chk($sformatf("R3 ignore value %0d", i), v, 16'hFC05);
    end
    rd(OFF_COUNT, v); chk("R2 init write keeps count", v, 4);
    wr(OFF_INIT, 16'h0004); rd(OFF_INIT, v); chk("R3 floor value", v, 4);

    // R4 control storage, halt bit set in pattern
    wr(OFF_CTRL, 16'h5A5A); rd(OFF_CTRL, v); chk("R4 ctrl storage", v, 16'h5A5A);
    // R12 unmapped offsets
    wr(5'h0A, 16'hFFFF);
    rd(5'h0A, v); chk("R12 read 0x0A", v, 0);
    rd(5'h02, v); chk("R12 read 0x02", v, 0);
    rd(5'h13, v); chk("R12 read 0x13", v, 0);
    rd(OFF_CTRL, v); chk("R12 ctrl untouched", v, 16'h5A5A);
    rd(OFF_INIT, v); chk("R12 init untouched", v, 4);

    // R5 R6 R7 sweep of start values
    for (int n = 4; n <= 16; n++) begin
      start_run(n);
      watch(2*n*T + 2, ka, kb, np, kp);
      chk($sformatf("R5 R6 first expiry n=%0d", n), ka, n*T);
      chk($sformatf("R7 second expiry n=%0d", n), kb, 2*n*T);
      chk($sformatf("R7 pulse count n=%0d", n), np, 1);
      chk($sformatf("R7 pulse cycle n=%0d", n), kp, 2*n*T);
    end

    // R2 R5 live count every cycle
    start_run(5);
    addr = OFF_COUNT;
    for (int k = 1; k <= 5*T + 2*T; k++) begin
      @(negedge clk); #1;
      chk($sformatf("R2 R5 count k=%0d", k), int'(rdata), 5 - (k % (5*T)) / T);
    end

    // R4 halt mid-run then resume
    start_run(6);
    repeat (6) @(negedge clk);
    wr(OFF_CTRL, 16'h0800);
    repeat (20) @(negedge clk);
    rd(OFF_COUNT, v); chk("R4 frozen mid-run", v, 4);
    wr(OFF_CTRL, 16'h0000);
    watch(4*T + 1, ka, kb, np, kp);
    chk("R4 resume fresh phase", ka, 4*T);

    // R8 reboot inhibited
    reboot_block = 1;
    start_run(4);
    watch(2*4*T + 2, ka, kb, np, kp);
    chk("R8 no pulse", np, 0);
    chk("R8 second flag still set", kb, 2*4*T);
    reboot_block = 0;

    // R11 write-one-to-clear
    wr(OFF_CTRL, 16'h0800);
    wr(OFF_STAT_A, 16'h0000); rd(OFF_STAT_A, v); chk("R11 write 0 keeps a", v, 1);
    wr(OFF_STAT_A, 16'hFFFE); rd(OFF_STAT_A, v); chk("R11 other bits keep a", v, 1);
    wr(OFF_STAT_A, 16'h0001); rd(OFF_STAT_A, v); chk("R11 clear a", v, 0);
    wr(OFF_STAT_B, 16'h0000); rd(OFF_STAT_B, v); chk("R11 write 0 keeps b", v, 1);
    wr(OFF_STAT_B, 16'h0001); rd(OFF_STAT_B, v); chk("R11 clear b", v, 0);

    // R9 restart between expiries cancels pending
    start_run(4);
    watch(13, ka, kb, np, kp);
    chk("R9 first expiry", ka, 4*T);
    wr(OFF_STAT_A, 16'h0001);
    wr(OFF_COUNT, 16'h0);
    watch(2*4*T + 2, ka, kb, np, kp);
    chk("R9 expiry after restart", ka, 4*T);
    chk("R9 second flag delayed", kb, 2*4*T);
    chk("R9 pulse delayed", kp, 2*4*T);
    chk("R9 single pulse", np, 1);

    // R10 restart on the expiring tick
    start_run(4);
    repeat (10) @(negedge clk);
    wr(OFF_COUNT, 16'h0);
    rd(OFF_STAT_A, v); chk("R10 no expiry flag", v, 0);
    rd(OFF_COUNT, v);  chk("R10 count reloaded", v, 4);
    watch(4*T + 1, ka, kb, np, kp);
    chk("R10 next expiry", ka, 4*T);
    chk("R10 no pulse", np, 0);

    finish_run();
  end
endmodule